// File: doc/BRIEF.md
# Asynchronous Bus Master Cycle Sequencer

This block runs one memory read or write at a time on a 32-bit asynchronous bus on behalf of an internal client. The client raises a request carrying a word address, a three-bit status code, a direction and write data. The sequencer then steps through a T1 bus state followed by one or more T2 states. It drives an active-low cycle-start strobe, an address strobe and a data strobe. The cycle ends on either of two terminations: a two-bit active-low acknowledge, sampled on bus falling edges, or an active-low synchronous termination, sampled on bus rising edges. When a read completes, the latched data goes back to the client with a one-tick done pulse.

The design uses a single clock, `clk_i`, running at twice the bus rate. A phase bit alternates between bus-rising ticks (even) and bus-falling ticks (odd), and the generated bus clock appears on `bus_clk_o`. Timing below is given in `clk_i` ticks. Edge 0 is the tick that starts the cycle, edge 1 is the falling edge of T1, and each later pair of ticks is one T2.

Top module: `abm_seq_top`

## Requirements
- R1: During reset, and straight after an asynchronous reset in the middle of a cycle, `cs_no`, `as_no` and `ds_no` are 1, and `busy_o`, `done_o` and `data_oe_o` are 0.
- R2: A request is taken only in idle and only on an even (bus-rising) tick. At that edge `cs_no` goes 0 and `busy_o` goes 1. `addr_o`, `stat_o` and `dir_o` (1 = write) take the request values and stay stable until the cycle ends. A request held high during a cycle is not taken again until the tick after done, and it starts at the next even tick.
- R3: At edge 1, `cs_no` returns to 1 and `as_no` goes 0. `cs_no` is therefore low for exactly one tick.
- R4: The acknowledge `ack_ni` counts when it is not 2'b11 (2'b10, 2'b01 and 2'b00 all count). It is sampled only at odd edges. An acknowledge seen at edge e releases the strobes at edge e+2 and raises done at edge e+3.
- R5: `term_ni` counts when it is 0, and it is sampled only at even edges from 2 onward. A termination seen at edge e releases the strobes at e+1 and raises done at e+2. When both paths apply, the earlier end wins.
- R6: With no valid termination, T2 repeats, and each wait state adds two ticks.
- R7: For a read, `ds_no` goes 0 at edge 1. `data_i` is captured only at the releasing edge and appears on `rdata_o` together with `done_o`.
- R8: For a write, `data_oe_o` is 1 from edge 1 until the done edge. `ds_no` goes 0 at edge 3 only if that edge does not release the strobes. A zero-wait write never asserts `ds_no`.
- R9: `as_no` and `ds_no` go high at the same releasing edge, which is always an odd edge.
- R10: The shortest cycle has done at edge 4, which is two bus clocks.
- R11: `done_o` is a single-tick pulse. `busy_o` is 0 while it is high.
- R12: `bus_clk_o` is 1 after every even tick and 0 after every odd tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Double-rate clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Client cycle request |
| req_addr_i | input | 31 | Word address |
| req_stat_i | input | 3 | Bus status code |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_wdata_i | input | 32 | Write data |
| busy_o | output | 1 | Cycle in progress |
| done_o | output | 1 | One-tick end-of-cycle pulse |
| rdata_o | output | 32 | Captured read data |
| bus_clk_o | output | 1 | Generated bus clock |
| cs_no | output | 1 | Cycle-start strobe, active low |
| as_no | output | 1 | Address strobe, active low |
| ds_no | output | 1 | Data strobe, active low |
| addr_o | output | 31 | Bus address |
| stat_o | output | 3 | Bus status |
| dir_o | output | 1 | Bus direction, 1 = write |
| data_o | output | 32 | Write data to bus |
| data_oe_o | output | 1 | Write data drive enable |
| data_i | input | 32 | Read data from bus |
| ack_ni | input | 2 | Asynchronous acknowledge, active low |
| term_ni | input | 1 | Synchronous termination, active low |

## Verification
The bench holds each termination input low for a single tick and moves that tick around the cycle. An acknowledge is placed on even edges and a termination on odd edges, where both must be ignored; a design that sampled them there would end early. Both paths are also made true together, so the bench can see whether the earlier end wins. Read data is valid only at the releasing edge, which exposes a capture that is one tick early or late. Writes are run with and without wait states, which catches a data strobe fired in a zero-wait write. A request held high through a whole cycle catches a sequencer that restarts before idle, or restarts on a bus falling edge.

// File: rtl/abm_pkg.sv
package abm_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_T1F,
    ST_T2R,
    ST_T2F,
    ST_END
  } abm_state_e;
endpackage

// File: rtl/abm_phase_gen.sv
module abm_phase_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic ph_o,
  output logic bus_clk_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_o      <= 1'b0;
      bus_clk_o <= 1'b0;
    end else begin
      ph_o      <= ~ph_o;
      bus_clk_o <= ~ph_o;
    end
  end
endmodule

// File: rtl/abm_term_detect.sv
module abm_term_detect
  import abm_pkg::*;
#(
  parameter int unsigned ACK_W = 2
) (
  input  abm_state_e       state_i,
  input  logic [ACK_W-1:0] ack_ni,
  input  logic             term_ni,
  output logic             ack_hit_o,
  output logic             term_hit_o
);
  // ack only on falling-edge states, term only on rising T2
  always_comb begin
    ack_hit_o  = ((state_i == ST_T1F) || (state_i == ST_T2F)) && !(&ack_ni);
    term_hit_o = (state_i == ST_T2R) && !term_ni;
  end
endmodule

// File: rtl/abm_bus_regs.sv
module abm_bus_regs #(
  parameter int unsigned ADDR_W = 31,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              rd_latch_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [STAT_W-1:0] req_stat_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  input  logic [DATA_W-1:0] data_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              dir_o,
  output logic [DATA_W-1:0] data_o,
  output logic [DATA_W-1:0] rdata_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_o <= '0;
      stat_o <= '0;
      dir_o  <= 1'b0;
      data_o <= '0;
    end else if (start_i) begin
      addr_o <= req_addr_i;
      stat_o <= req_stat_i;
      dir_o  <= req_write_i;
      data_o <= req_wdata_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         rdata_o <= '0;
    else if (rd_latch_i) rdata_o <= data_i;
  end
endmodule

// File: rtl/abm_seq_fsm.sv
module abm_seq_fsm
  import abm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ph_i,
  input  logic       req_i,
  input  logic       dir_i,
  input  logic       ack_hit_i,
  input  logic       term_hit_i,
  output abm_state_e state_o,
  output logic       start_o,
  output logic       rd_latch_o,
  output logic       cs_no,
  output logic       as_no,
  output logic       ds_no,
  output logic       data_oe_o,
  output logic       done_o,
  output logic       busy_o
);
  logic ack_seen_q, last_q;

  always_comb begin
    start_o    = (state_o == ST_IDLE) && !ph_i && req_i;
    rd_latch_o = (state_o == ST_T2F) && last_q && !dir_i;
    busy_o     = (state_o != ST_IDLE);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_o    <= ST_IDLE;
      ack_seen_q <= 1'b0;
      last_q     <= 1'b0;
      cs_no      <= 1'b1;
      as_no      <= 1'b1;
      ds_no      <= 1'b1;
      data_oe_o  <= 1'b0;
      done_o     <= 1'b0;
    end else begin
      done_o <= 1'b0;
      unique case (state_o)
        ST_IDLE: if (start_o) begin
          cs_no   <= 1'b0;
          state_o <= ST_T1F;
        end
        ST_T1F: begin
          cs_no      <= 1'b1;
          as_no      <= 1'b0;
          ds_no      <= dir_i;      // reads strobe data now
          data_oe_o  <= dir_i;
          ack_seen_q <= ack_hit_i;
          state_o    <= ST_T2R;
        end
        ST_T2R: begin
          last_q  <= ack_seen_q | term_hit_i;
          state_o <= ST_T2F;
        end
        ST_T2F: begin
          if (last_q) begin
            as_no      <= 1'b1;
            ds_no      <= 1'b1;
            last_q     <= 1'b0;
            ack_seen_q <= 1'b0;
            state_o    <= ST_END;
          end else begin
            ds_no      <= 1'b0;     // waited write strobes here
            ack_seen_q <= ack_hit_i;
            state_o    <= ST_T2R;
          end
        end
        ST_END: begin
          done_o    <= 1'b1;
          data_oe_o <= 1'b0;
          state_o   <= ST_IDLE;
        end
        default: state_o <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/abm_seq_top.sv
module abm_seq_top
  import abm_pkg::*;
#(
  parameter int unsigned ADDR_W = 31,
  parameter int unsigned DATA_W = 32,
  parameter int unsigned STAT_W = 3,
  parameter int unsigned ACK_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [ADDR_W-1:0] req_addr_i,
  input  logic [STAT_W-1:0] req_stat_i,
  input  logic              req_write_i,
  input  logic [DATA_W-1:0] req_wdata_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [DATA_W-1:0] rdata_o,
  output logic              bus_clk_o,
  output logic              cs_no,
  output logic              as_no,
  output logic              ds_no,
  output logic [ADDR_W-1:0] addr_o,
  output logic [STAT_W-1:0] stat_o,
  output logic              dir_o,
  output logic [DATA_W-1:0] data_o,
  output logic              data_oe_o,
  input  logic [DATA_W-1:0] data_i,
  input  logic [ACK_W-1:0]  ack_ni,
  input  logic              term_ni
);
  logic       ph, start, rd_latch, ack_hit, term_hit;
  abm_state_e state;

  abm_phase_gen i_phase (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .ph_o     (ph),
    .bus_clk_o(bus_clk_o)
  );

  abm_term_detect #(.ACK_W(ACK_W)) i_term (
    .state_i   (state),
    .ack_ni    (ack_ni),
    .term_ni   (term_ni),
    .ack_hit_o (ack_hit),
    .term_hit_o(term_hit)
  );

  abm_seq_fsm i_fsm (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ph_i      (ph),
    .req_i     (req_i),
    .dir_i     (dir_o),
    .ack_hit_i (ack_hit),
    .term_hit_i(term_hit),
    .state_o   (state),
    .start_o   (start),
    .rd_latch_o(rd_latch),
    .cs_no     (cs_no),
    .as_no     (as_no),
    .ds_no     (ds_no),
    .data_oe_o (data_oe_o),
    .done_o    (done_o),
    .busy_o    (busy_o)
  );

  abm_bus_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .STAT_W(STAT_W)) i_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .start_i    (start),
    .rd_latch_i (rd_latch),
    .req_addr_i (req_addr_i),
    .req_stat_i (req_stat_i),
    .req_write_i(req_write_i),
    .req_wdata_i(req_wdata_i),
    .data_i     (data_i),
    .addr_o     (addr_o),
    .stat_o     (stat_o),
    .dir_o      (dir_o),
    .data_o     (data_o),
    .rdata_o    (rdata_o)
  );
endmodule

// File: rtl/abm_seq_chk.sv
module abm_seq_chk #(
  parameter int unsigned ADDR_W = 31,
  parameter int unsigned STAT_W = 3
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              cs_no,
  input logic              as_no,
  input logic              ds_no,
  input logic              busy_o,
  input logic              done_o,
  input logic              bus_clk_o,
  input logic              data_oe_o,
  input logic              dir_o,
  input logic [ADDR_W-1:0] addr_o,
  input logic [STAT_W-1:0] stat_o
);
  AST_CS_ONE_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cs_no |=> cs_no); // R3
  AST_AS_AFTER_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(as_no) |-> (cs_no && $past(!cs_no))); // R3
  AST_START_EVEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(cs_no) |-> (bus_clk_o && busy_o)); // R2
  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> ($stable(addr_o) && $stable(stat_o) && $stable(dir_o))); // R2
  AST_DS_IN_AS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ds_no |-> !as_no); // R8
  AST_STROBE_PAIR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(as_no) |-> (ds_no && !bus_clk_o)); // R9
  AST_OE_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_oe_o |-> dir_o); // R8
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (!busy_o && as_no && ds_no && !data_oe_o)); // R11
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o); // R11
  AST_BUS_CLK_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> (bus_clk_o != $past(bus_clk_o))); // R12
endmodule

bind abm_seq_top abm_seq_chk #(.ADDR_W(ADDR_W), .STAT_W(STAT_W)) i_chk (.*);

// File: tb/test_abm_seq_top.sv
`timescale 1ns/1ps
module test_abm_seq_top;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        req_i = 1'b0, req_write_i = 1'b0;
  logic [30:0] req_addr_i = '0;
  logic [2:0]  req_stat_i = '0;
  logic [31:0] req_wdata_i = '0, data_i = '0;
  logic [1:0]  ack_ni = 2'b11;
  logic        term_ni = 1'b1;
  logic        busy_o, done_o, bus_clk_o, cs_no, as_no, ds_no, dir_o, data_oe_o;
  logic [31:0] rdata_o, data_o;
  logic [30:0] addr_o;
  logic [2:0]  stat_o;
  int n_chk = 0, n_bad = 0;

  always #10 clk_i = ~clk_i;

  abm_seq_top i_abm_seq_top (.*);

  typedef struct packed {
    logic        wr;
    logic [3:0]  ack_e;
    logic [1:0]  ack_v;
    logic [3:0]  term_e;
    logic [30:0] addr;
    logic [2:0]  st;
    logic [31:0] dat;
  } vec_t;

  // ack_e odd = valid, even = ignored; term_e even >=2 valid, odd ignored; 0 = none
  localparam vec_t VECS [9] = '{
    '{1'b0, 4'd1, 2'b10, 4'd0, 31'h0000_1234, 3'd1, 32'hA5A5_0001},
    '{1'b0, 4'd0, 2'b11, 4'd2, 31'h7FFF_FFFF, 3'd2, 32'h1357_9BDF},
    '{1'b1, 4'd1, 2'b01, 4'd0, 31'h0123_4567, 3'd5, 32'hDEAD_BEEF},
    '{1'b1, 4'd0, 2'b11, 4'd2, 31'h0000_0001, 3'd7, 32'h0F0F_F0F0},
    '{1'b0, 4'd3, 2'b00, 4'd0, 31'h5555_AAAA, 3'd3, 32'hCAFE_F00D},
    '{1'b1, 4'd5, 2'b10, 4'd0, 31'h2AAA_5555, 3'd4, 32'h8765_4321},
    '{1'b1, 4'd2, 2'b00, 4'd6, 31'h1000_0000, 3'd6, 32'h0000_FFFF},
    '{1'b0, 4'd7, 2'b10, 4'd3, 31'h0ABC_DEF0, 3'd0, 32'hFFFF_0000},
    '{1'b0, 4'd3, 2'b01, 4'd2, 31'h3333_3333, 3'd1, 32'h2468_ACE0}
  };

  task automatic chk(input string req, input string what, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  function automatic int exp_done(input vec_t v);
    int d = 1000;
    if (v.ack_e[0]) d = int'(v.ack_e) + 3;
    if (!v.term_e[0] && v.term_e >= 2 && int'(v.term_e) + 2 < d) d = int'(v.term_e) + 2;
    return d;
  endfunction

  task automatic run_vec(input vec_t v);
    int d = exp_done(v);
    int tries = 0;
    req_addr_i = v.addr; req_stat_i = v.st; req_write_i = v.wr; req_wdata_i = v.dat;
    req_i = 1'b1; ack_ni = 2'b11; term_ni = 1'b1;
    do begin tick(); tries++; end while (!busy_o && tries < 4);
    chk("R2", "start accepted", busy_o, 1'b1);
    chk("R2", "cs at start", cs_no, 1'b0);
    chk("R12", "bus_clk at start", bus_clk_o, 1'b1);
    req_i = 1'b0;
    for (int k = 1; k <= d; k++) begin
      ack_ni  = (k == int'(v.ack_e)) ? v.ack_v : 2'b11;
      term_ni = !(k == int'(v.term_e));
      data_i  = (k == d - 1) ? v.dat : ~v.dat;
      tick();
      chk("R3", "cs_no", cs_no, 1'b1);
      chk("R4/R5 R9", "as_no", as_no, (k < d - 1) ? 1'b0 : 1'b1);
      if (v.wr) chk("R8", "ds_no write", ds_no, (k >= 3 && k < d - 1) ? 1'b0 : 1'b1);
      else      chk("R7", "ds_no read", ds_no, (k < d - 1) ? 1'b0 : 1'b1);
      chk("R8", "data_oe", data_oe_o, (v.wr && k < d) ? 1'b1 : 1'b0);
      chk("R6 R10", "busy", busy_o, (k < d) ? 1'b1 : 1'b0);
      chk("R11", "done", done_o, (k == d) ? 1'b1 : 1'b0);
      chk("R2", "addr hold", {addr_o, stat_o, dir_o}, {v.addr, v.st, v.wr});
      chk("R12", "bus_clk", bus_clk_o, (k % 2 == 0) ? 1'b1 : 1'b0);
      if (v.wr) chk("R8", "wdata", data_o, v.dat);
      if (k == d && !v.wr) chk("R7", "rdata", rdata_o, v.dat);
    end
    ack_ni = 2'b11; term_ni = 1'b1;
    tick();
    chk("R11", "done one tick", done_o, 1'b0);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    for (int c = 0; c < 20000; c++) @(posedge clk_i);
    n_bad++;
    $display("FAIL R6 watchdog: actual hung expected finish");
    summary();
  end

  initial begin
    @(negedge clk_i);
    chk("R1", "reset strobes", {cs_no, as_no, ds_no}, 3'b111);
    chk("R1", "reset busy/done/oe", {busy_o, done_o, data_oe_o}, 3'b000);
    @(negedge clk_i);
    rst_ni = 1'b1;
    foreach (VECS[i]) run_vec(VECS[i]);

    // R2: request held through a cycle restarts only after idle, on an even tick
    req_addr_i = 31'h0000_00AA; req_stat_i = 3'd2; req_write_i = 1'b0;
    req_i = 1'b1; ack_ni = 2'b00;
    tick();
    if (!busy_o) tick();
    chk("R2", "held req start", busy_o, 1'b1);
    tick(); tick(); tick(); tick();
    chk("R10", "min cycle done at edge 4", done_o, 1'b1);
    tick();
    chk("R2", "no restart on odd tick", busy_o, 1'b0);
    tick();
    chk("R2", "restart on even tick", {busy_o, cs_no}, 2'b10);
    req_i = 1'b0;
    tick(); tick(); tick(); tick(); tick();
    ack_ni = 2'b11;

    // R1: reset in the middle of a waited read
    req_write_i = 1'b0; req_i = 1'b1;
    tick();
    if (!busy_o) tick();
    req_i = 1'b0;
    tick(); tick(); tick();
    rst_ni = 1'b0;
    #1;
    chk("R1", "mid-cycle reset strobes", {cs_no, as_no, ds_no}, 3'b111);
    chk("R1", "mid-cycle reset busy/oe", {busy_o, data_oe_o}, 2'b00);
    @(negedge clk_i);
    rst_ni = 1'b1;
    tick(); tick();
    chk("R2", "idle after reset without request", {busy_o, as_no}, 2'b01);
    summary();
  end
endmodule